// File: doc/BRIEF.md
# Security-Masked Private Interrupt Register Bank

This block is the per-processor register bank for a set of private interrupts (32 by default). Software reaches it over a simple memory-mapped bus with no wait states. The bank holds a group bit, a group-modifier bit, and enable, pending and active bits for each interrupt. It also holds an 8-bit priority for each interrupt, a 32-bit access-control word for software-generated interrupts, a sleep handshake register, two 64-bit base-address registers and a read-only type word. The state vectors leave the block on plain output ports for the neighbouring pending and acceptance logic.

Every bus access carries a secure flag. A chip-level security-disable input changes the rules. While security is enabled, a non-secure access may only see or change interrupts whose group bit is 1. The bitmap registers are filtered through a per-interrupt mask. The priority bytes of permitted interrupts are shown to non-secure software in a shifted form. The group, group-modifier and access-control registers are restricted as a whole. Accesses that match nothing return zero and change nothing, and the bus never reports an error.

Top module: `redist_regbank`

## Requirements
- R1: When an access is non-secure and `sec_dis_i` is 0, the mask applied to the enable, pending and active registers equals the group vector: bits of group-0 interrupts read 0 and ignore writes. In every other case the mask is all ones.
- R2: Enable is set at 0x100 and cleared at 0x180. Pending is set at 0x200 and cleared at 0x280. Active is set at 0x300 and cleared at 0x380. A set write ORs the masked data into the state, and a clear write removes the masked data bits. Both addresses of a pair read the same masked state.
- R3: A non-secure read (with `sec_dis_i`=0) of the priority byte of a group-1 interrupt returns the stored byte shifted left by one, truncated to 8 bits. For a group-0 interrupt it returns 0. Secure reads, and any read with `sec_dis_i`=1, return the stored byte.
- R4: A non-secure write (with `sec_dis_i`=0) to the priority byte of a group-1 interrupt stores 0x80 OR (data shifted right by one). The same write to a group-0 interrupt is ignored. Other writes store the data unchanged.
- R5: Priorities start at 0x400, one byte per interrupt. A 4-byte access at 0x400+4k covers interrupts 4k to 4k+3, with the lowest interrupt in bits 7:0. A 1-byte access at 0x400+n reaches interrupt n.
- R6: The group register (0x080) reads 0 and ignores writes for non-secure accesses while `sec_dis_i` is 0.
- R7: The group-modifier register (0xD00) and the access-control register (0xE00) accept writes and return their value only for a secure access with `sec_dis_i`=0. Otherwise they read 0 and ignore writes.
- R8: In the sleep register (0x014), bit 0 is the only writable bit. Bit 1 takes the written bit-0 value in the same write, and all other bits read 0.
- R9: The control register (0x000) and the status register (0x010) read 0 and ignore writes. The type word (0x008, or 0x008/0x00C as halves) returns the TYPE_VAL parameter, and writes to it are ignored.
- R10: The base registers at 0x070 and 0x078 accept an 8-byte access, or a 4-byte access to either half, with the low half at the base offset.
- R11: The size code is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Size code 1, a size a register does not support, a misaligned access and an unmapped offset all read 0 and change no state.
- R12: Read data appears on `rdata_o` one cycle after the request and holds while no request is made. After reset, all state is 0 except the group vector, which takes GROUP_RST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the bank |
| size_i | input | 2 | Size code (0:1 B, 1:2 B, 2:4 B, 3:8 B) |
| wdata_i | input | 64 | Write data, right-aligned |
| sec_i | input | 1 | Access is secure |
| sec_dis_i | input | 1 | Chip-level security disable |
| rdata_o | output | 64 | Read data, one cycle after the request |
| grp_o | output | NIRQ | Group vector |
| grpmod_o | output | NIRQ | Group-modifier vector |
| en_o | output | NIRQ | Enable vector |
| pend_o | output | NIRQ | Pending vector |
| act_o | output | NIRQ | Active vector |
| prio_o | output | NIRQ*8 | Priorities, interrupt n at bits 8n+7:8n |
| sgi_acc_o | output | 32 | Access-control word for generated interrupts |

## Verification
The bitmap registers are exercised with all-ones patterns while the group vector is 0xF0, once as secure, once as non-secure and once with security disabled. Because a masked access and an unmasked access then produce visibly different values, these runs separate a missing mask from an inverted one. Priority bytes are written with distinct values in each lane, so a swapped lane order or a wrong byte index shows up. The value 0x40 is used to tell the non-secure shifted view apart from the raw one, for both reads and writes. Mixed-width and ill-sized accesses to the 64-bit registers and the bitmaps confirm that half selection is correct and that illegal sizes leave the state untouched.

// File: rtl/redist_pkg.sv
package redist_pkg;
   localparam int unsigned OFS_W  = 12;
   localparam int unsigned PRIO_W = 8;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam logic [OFS_W-1:0] A_CTRL     = 12'h000;
   localparam logic [OFS_W-1:0] A_TYPE_LO  = 12'h008;
   localparam logic [OFS_W-1:0] A_TYPE_HI  = 12'h00C;
   localparam logic [OFS_W-1:0] A_STAT     = 12'h010;
   localparam logic [OFS_W-1:0] A_SLEEP    = 12'h014;
   localparam logic [OFS_W-1:0] A_BASEA_LO = 12'h070;
   localparam logic [OFS_W-1:0] A_BASEA_HI = 12'h074;
   localparam logic [OFS_W-1:0] A_BASEB_LO = 12'h078;
   localparam logic [OFS_W-1:0] A_BASEB_HI = 12'h07C;
   localparam logic [OFS_W-1:0] A_GROUP    = 12'h080;
   localparam logic [OFS_W-1:0] A_EN_SET   = 12'h100;
   localparam logic [OFS_W-1:0] A_EN_CLR   = 12'h180;
   localparam logic [OFS_W-1:0] A_PD_SET   = 12'h200;
   localparam logic [OFS_W-1:0] A_PD_CLR   = 12'h280;
   localparam logic [OFS_W-1:0] A_AC_SET   = 12'h300;
   localparam logic [OFS_W-1:0] A_AC_CLR   = 12'h380;
   localparam logic [OFS_W-1:0] A_PRIO     = 12'h400;
   localparam logic [OFS_W-1:0] A_GMOD     = 12'hD00;
   localparam logic [OFS_W-1:0] A_SGIAC    = 12'hE00;
endpackage

// File: rtl/redist_secmask.sv
module redist_secmask #(
   parameter int unsigned NIRQ = 32
) (
   input  logic            sec_i,
   input  logic            sec_dis_i,
   input  logic [NIRQ-1:0] grp_i,
   output logic            ns_view_o,
   output logic [NIRQ-1:0] mask_o
);
   // Restricted view: non-secure caller while security is enforced.
   assign ns_view_o = ~sec_i & ~sec_dis_i;
   assign mask_o    = ns_view_o ? grp_i : {NIRQ{1'b1}};
endmodule

// File: rtl/redist_setclr.sv
module redist_setclr #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic         clr_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] mask_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;
   logic [W-1:0] eff;

   assign eff = data_i & mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (set_i) q <= q | eff;
      else if (clr_i) q <= q & ~eff;
   end

   assign q_o = q;
endmodule

// File: rtl/redist_prio_bank.sv
module redist_prio_bank
   import redist_pkg::*;
#(
   parameter int unsigned NIRQ = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_word_i,
   input  logic                   wr_byte_i,
   input  logic [4:0]             idx_i,
   input  logic [31:0]            wdata_i,
   input  logic                   ns_view_i,
   input  logic [NIRQ-1:0]        grp_i,
   output logic [NIRQ*PRIO_W-1:0] prio_o,
   output logic [NIRQ*PRIO_W-1:0] view_o
);
   for (genvar i = 0; i < NIRQ; i++) begin : g_irq
      localparam int unsigned LANE = i % 4;
      logic              hit;
      logic              allow;
      logic [PRIO_W-1:0] din;
      logic [PRIO_W-1:0] q;

      assign hit   = (wr_word_i && (idx_i[4:2] == 3'(i / 4))) ||
                     (wr_byte_i && (idx_i == 5'(i)));
      assign allow = ~ns_view_i | grp_i[i];
      assign din   = wr_word_i ? wdata_i[PRIO_W*LANE +: PRIO_W] : wdata_i[PRIO_W-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (hit && allow)
            q <= ns_view_i ? {1'b1, din[PRIO_W-1:1]} : din;
      end

      assign prio_o[PRIO_W*i +: PRIO_W] = q;
      assign view_o[PRIO_W*i +: PRIO_W] = !ns_view_i ? q :
                                          grp_i[i]   ? {q[PRIO_W-2:0], 1'b0} : '0;
   end
endmodule

// File: rtl/redist_regbank.sv
module redist_regbank
   import redist_pkg::*;
#(
   parameter int unsigned NIRQ      = 32,
   parameter logic [31:0] GROUP_RST = 32'h0,
   parameter logic [63:0] TYPE_VAL  = 64'h0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_i,
   input  logic                   we_i,
   input  logic [OFS_W-1:0]       addr_i,
   input  logic [1:0]             size_i,
   input  logic [63:0]            wdata_i,
   input  logic                   sec_i,
   input  logic                   sec_dis_i,
   output logic [63:0]            rdata_o,
   output logic [NIRQ-1:0]        grp_o,
   output logic [NIRQ-1:0]        grpmod_o,
   output logic [NIRQ-1:0]        en_o,
   output logic [NIRQ-1:0]        pend_o,
   output logic [NIRQ-1:0]        act_o,
   output logic [NIRQ*PRIO_W-1:0] prio_o,
   output logic [31:0]            sgi_acc_o
);
   localparam int unsigned NVEC = 3;  // 0 enable, 1 pending, 2 active

   if (NIRQ < 4 || NIRQ > 32 || (NIRQ % 4) != 0) begin : g_bad_nirq
      $error("redist_regbank: NIRQ must be a multiple of 4 in 4..32");
   end

   logic [NIRQ-1:0] grp_q, gmod_q;
   logic [31:0]     sgiac_q;
   logic [1:0]      sleep_q;
   logic [63:0]     basea_q, baseb_q;
   logic [63:0]     rdata_q;

   logic            ns_view, secure_cfg;
   logic [NIRQ-1:0] acc_mask;

   redist_secmask #(.NIRQ(NIRQ)) u_mask (
      .sec_i     (sec_i),
      .sec_dis_i (sec_dis_i),
      .grp_i     (grp_q),
      .ns_view_o (ns_view),
      .mask_o    (acc_mask)
   );
   assign secure_cfg = sec_i & ~sec_dis_i;

   // Size and alignment qualifiers
   logic is_byte, word_ok, dword_ok, prio_hit;
   assign is_byte  = (size_i == SZ_BYTE);
   assign word_ok  = (size_i == SZ_WORD)  && (addr_i[1:0] == 2'b00);
   assign dword_ok = (size_i == SZ_DWORD) && (addr_i[2:0] == 3'b000);
   assign prio_hit = (addr_i[OFS_W-1:5] == A_PRIO[OFS_W-1:5]) &&
                     (32'(addr_i[4:0]) < NIRQ);

   // Write strobes
   logic [NVEC-1:0] set_stb, clr_stb;
   logic            grp_we, gmod_we, sgiac_we, sleep_we;
   logic [1:0]      basea_we, baseb_we;
   logic            prio_wword, prio_wbyte;

   always_comb begin
      set_stb = '0;  clr_stb = '0;
      grp_we = 1'b0; gmod_we = 1'b0; sgiac_we = 1'b0; sleep_we = 1'b0;
      basea_we = 2'b00; baseb_we = 2'b00;
      prio_wword = 1'b0; prio_wbyte = 1'b0;
      if (req_i && we_i) begin
         if (word_ok) begin
            case (addr_i)
               A_GROUP:    grp_we     = ~ns_view;
               A_EN_SET:   set_stb[0] = 1'b1;
               A_EN_CLR:   clr_stb[0] = 1'b1;
               A_PD_SET:   set_stb[1] = 1'b1;
               A_PD_CLR:   clr_stb[1] = 1'b1;
               A_AC_SET:   set_stb[2] = 1'b1;
               A_AC_CLR:   clr_stb[2] = 1'b1;
               A_GMOD:     gmod_we    = secure_cfg;
               A_SGIAC:    sgiac_we   = secure_cfg;
               A_SLEEP:    sleep_we   = 1'b1;
               A_BASEA_LO: basea_we   = 2'b01;
               A_BASEA_HI: basea_we   = 2'b10;
               A_BASEB_LO: baseb_we   = 2'b01;
               A_BASEB_HI: baseb_we   = 2'b10;
               default:    prio_wword = prio_hit;
            endcase
         end else if (dword_ok) begin
            case (addr_i)
               A_BASEA_LO: basea_we = 2'b11;
               A_BASEB_LO: baseb_we = 2'b11;
               default: ;
            endcase
         end else if (is_byte) begin
            prio_wbyte = prio_hit;
         end
      end
   end

   // Set/clear bitmap registers
   logic [NIRQ-1:0] vec_q [NVEC];
   for (genvar k = 0; k < NVEC; k++) begin : g_vec
      redist_setclr #(.W(NIRQ)) u_vec (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_stb[k]),
         .clr_i  (clr_stb[k]),
         .data_i (wdata_i[NIRQ-1:0]),
         .mask_i (acc_mask),
         .q_o    (vec_q[k])
      );
   end

   // Priority storage
   logic [NIRQ*PRIO_W-1:0] prio_view;
   redist_prio_bank #(.NIRQ(NIRQ)) u_prio (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_word_i (prio_wword),
      .wr_byte_i (prio_wbyte),
      .idx_i     (addr_i[4:0]),
      .wdata_i   (wdata_i[31:0]),
      .ns_view_i (ns_view),
      .grp_i     (grp_q),
      .prio_o    (prio_o),
      .view_o    (prio_view)
   );

   // Plain registers
   logic [31:0] hi_half_d;
   assign hi_half_d = dword_ok ? wdata_i[63:32] : wdata_i[31:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q   <= GROUP_RST[NIRQ-1:0];
         gmod_q  <= '0;
         sgiac_q <= '0;
         sleep_q <= '0;
         basea_q <= '0;
         baseb_q <= '0;
      end else begin
         if (grp_we)      grp_q   <= wdata_i[NIRQ-1:0];
         if (gmod_we)     gmod_q  <= wdata_i[NIRQ-1:0];
         if (sgiac_we)    sgiac_q <= wdata_i[31:0];
         if (sleep_we)    sleep_q <= {2{wdata_i[0]}};
         if (basea_we[0]) basea_q[31:0]  <= wdata_i[31:0];
         if (basea_we[1]) basea_q[63:32] <= hi_half_d;
         if (baseb_we[0]) baseb_q[31:0]  <= wdata_i[31:0];
         if (baseb_we[1]) baseb_q[63:32] <= hi_half_d;
      end
   end

   // Read mux
   logic [63:0] rd_val;
   always_comb begin
      rd_val = '0;
      if (word_ok) begin
         case (addr_i)
            A_TYPE_LO:            rd_val[31:0] = TYPE_VAL[31:0];
            A_TYPE_HI:            rd_val[31:0] = TYPE_VAL[63:32];
            A_SLEEP:              rd_val[31:0] = {30'b0, sleep_q};
            A_BASEA_LO:           rd_val[31:0] = basea_q[31:0];
            A_BASEA_HI:           rd_val[31:0] = basea_q[63:32];
            A_BASEB_LO:           rd_val[31:0] = baseb_q[31:0];
            A_BASEB_HI:           rd_val[31:0] = baseb_q[63:32];
            A_GROUP:              rd_val[31:0] = ns_view ? 32'h0 : 32'(grp_q);
            A_EN_SET, A_EN_CLR:   rd_val[31:0] = 32'(vec_q[0] & acc_mask);
            A_PD_SET, A_PD_CLR:   rd_val[31:0] = 32'(vec_q[1] & acc_mask);
            A_AC_SET, A_AC_CLR:   rd_val[31:0] = 32'(vec_q[2] & acc_mask);
            A_GMOD:               rd_val[31:0] = secure_cfg ? 32'(gmod_q) : 32'h0;
            A_SGIAC:              rd_val[31:0] = secure_cfg ? sgiac_q : 32'h0;
            default:
               if (prio_hit) rd_val[31:0] = prio_view[{addr_i[4:2], 5'b0} +: 32];
         endcase
      end else if (dword_ok) begin
         case (addr_i)
            A_TYPE_LO:  rd_val = TYPE_VAL;
            A_BASEA_LO: rd_val = basea_q;
            A_BASEB_LO: rd_val = baseb_q;
            default: ;
         endcase
      end else if (is_byte && prio_hit) begin
         rd_val[7:0] = prio_view[{addr_i[4:0], 3'b0} +: 8];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata_q <= '0;
      else if (req_i) rdata_q <= we_i ? 64'h0 : rd_val;
   end

   assign rdata_o   = rdata_q;
   assign grp_o     = grp_q;
   assign grpmod_o  = gmod_q;
   assign en_o      = vec_q[0];
   assign pend_o    = vec_q[1];
   assign act_o     = vec_q[2];
   assign sgi_acc_o = sgiac_q;
endmodule

// File: rtl/redist_regbank_chk.sv
module redist_regbank_chk
   import redist_pkg::*;
#(
   parameter int unsigned NIRQ = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_i,
   input logic             we_i,
   input logic [OFS_W-1:0] addr_i,
   input logic [1:0]       size_i,
   input logic             sec_i,
   input logic             sec_dis_i,
   input logic [63:0]      rdata_o,
   input logic [NIRQ-1:0]  grp_o,
   input logic [NIRQ-1:0]  grpmod_o,
   input logic [NIRQ-1:0]  en_o,
   input logic [NIRQ-1:0]  pend_o,
   input logic [NIRQ-1:0]  act_o,
   input logic [31:0]      sgi_acc_o
);
   logic ns_wr, ns_enf;
   assign ns_enf = ~sec_i & ~sec_dis_i;
   assign ns_wr  = req_i & we_i & ns_enf;

   // R1: a restricted write never moves a bit of a group-0 interrupt
   a_r1_ns_protect: assert property (@(posedge clk) disable iff (!rst_n)
      ns_wr |=> (((en_o   ^ $past(en_o))   & ~$past(grp_o)) == '0) &&
                (((pend_o ^ $past(pend_o)) & ~$past(grp_o)) == '0) &&
                (((act_o  ^ $past(act_o))  & ~$past(grp_o)) == '0));

   // R6: group vector is locked against restricted writes
   a_r6_group_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ns_wr |=> $stable(grp_o));

   // R7: secure-only configuration registers
   a_r7_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && we_i && !(sec_i && !sec_dis_i)) |=> ($stable(grpmod_o) && $stable(sgi_acc_o)));

   // R8: the two sleep bits always read back equal
   a_r8_sleep_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i && size_i == SZ_WORD && addr_i == A_SLEEP) |=> (rdata_o[1] == rdata_o[0]));

   // R3: shifted view always has a clear least significant bit
   a_r3_ns_prio_lsb: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i && ns_enf && size_i == SZ_BYTE && addr_i[OFS_W-1:5] == A_PRIO[OFS_W-1:5])
      |=> (rdata_o[0] == 1'b0));

   // R11: two-byte accesses read zero and leave state alone
   a_r11_half_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !we_i && size_i == SZ_HALF) |=> (rdata_o == 64'h0));

   a_r11_half_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && we_i && size_i == SZ_HALF) |=>
      ($stable(en_o) && $stable(pend_o) && $stable(act_o) && $stable(grp_o) &&
       $stable(grpmod_o) && $stable(sgi_acc_o)));

   // R12: read data holds while idle
   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> $stable(rdata_o));
endmodule

bind redist_regbank redist_regbank_chk #(.NIRQ(NIRQ)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_i     (req_i),
   .we_i      (we_i),
   .addr_i    (addr_i),
   .size_i    (size_i),
   .sec_i     (sec_i),
   .sec_dis_i (sec_dis_i),
   .rdata_o   (rdata_o),
   .grp_o     (grp_o),
   .grpmod_o  (grpmod_o),
   .en_o      (en_o),
   .pend_o    (pend_o),
   .act_o     (act_o),
   .sgi_acc_o (sgi_acc_o)
);

// File: tb/test_redist_regbank.sv
module test_redist_regbank;
   import redist_pkg::*;

   localparam int unsigned NIRQ = 32;
   localparam logic [31:0] GRST = 32'h0000_00F0;
   localparam logic [63:0] TVAL = 64'h0123_4567_89AB_CDEF;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   req = 1'b0, we = 1'b0, sec = 1'b0, dis = 1'b0;
   logic [OFS_W-1:0]       addr = '0;
   logic [1:0]             size = 2'd2;
   logic [63:0]            wdata = '0;
   logic [63:0]            rdata;
   logic [NIRQ-1:0]        grp, gmod, en, pend, act;
   logic [NIRQ*PRIO_W-1:0] prio;
   logic [31:0]            sgiac;

   int  n_run = 0, n_fail = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   redist_regbank #(.NIRQ(NIRQ), .GROUP_RST(GRST), .TYPE_VAL(TVAL)) i_redist_regbank (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
      .wdata_i(wdata), .sec_i(sec), .sec_dis_i(dis), .rdata_o(rdata),
      .grp_o(grp), .grpmod_o(gmod), .en_o(en), .pend_o(pend), .act_o(act),
      .prio_o(prio), .sgi_acc_o(sgiac)
   );

   task automatic check(string tag, logic [63:0] actual, logic [63:0] expected);
      n_run++;
      if (actual !== expected) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, actual, expected);
      end
   endtask

   task automatic wr(logic [OFS_W-1:0] a, logic [1:0] sz, logic [63:0] d, logic s);
      @(negedge clk);
      req = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d; sec = s;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic rd(logic [OFS_W-1:0] a, logic [1:0] sz, logic s, output logic [63:0] d);
      @(negedge clk);
      req = 1'b1; we = 1'b0; addr = a; size = sz; sec = s;
      @(negedge clk);
      req = 1'b0;
      d = rdata;
   endtask

   task automatic t_reset();
      check("R12 group reset", 64'(grp), 64'(GRST));
      check("R12 zero vectors", 64'(en | pend | act | gmod), 64'h0);
      check("R12 zero prio/acc", 64'(|prio) | 64'(sgiac), 64'h0);
      check("R12 rdata reset", rdata, 64'h0);
   endtask

   task automatic t_mask();
      logic [63:0] d;
      wr(A_EN_SET, SZ_WORD, 64'hFFFF_FFFF, 1'b1);
      check("R2 secure set", 64'(en), 64'hFFFF_FFFF);
      rd(A_EN_SET, SZ_WORD, 1'b0, d);
      check("R1 ns read masked", d, 64'h0000_00F0);
      rd(A_EN_CLR, SZ_WORD, 1'b0, d);
      check("R2 clear alias reads same", d, 64'h0000_00F0);
      wr(A_EN_CLR, SZ_WORD, 64'hFFFF_FFFF, 1'b0);
      check("R1 ns clear masked", 64'(en), 64'hFFFF_FF0F);
      rd(A_EN_SET, SZ_WORD, 1'b1, d);
      check("R1 secure read full", d, 64'hFFFF_FF0F);
      dis = 1'b1;
      wr(A_EN_CLR, SZ_WORD, 64'h0000_000F, 1'b0);
      check("R1 disabled ns clear unmasked", 64'(en), 64'hFFFF_FF00);
      dis = 1'b0;
   endtask

   task automatic t_pend_act();
      logic [63:0] d;
      wr(A_PD_SET, SZ_WORD, 64'h0000_1234, 1'b1);
      check("R2 pending set", 64'(pend), 64'h0000_1234);
      wr(A_PD_CLR, SZ_WORD, 64'h0000_0204, 1'b1);
      check("R2 pending clear", 64'(pend), 64'h0000_1030);
      wr(A_AC_SET, SZ_WORD, 64'h0000_00FF, 1'b0);
      check("R1 ns active set masked", 64'(act), 64'h0000_00F0);
      rd(A_AC_CLR, SZ_WORD, 1'b1, d);
      check("R2 active clear alias read", d, 64'h0000_00F0);
   endtask

   task automatic t_prio();
      logic [63:0] d;
      wr(A_PRIO, SZ_WORD, 64'h4433_2211, 1'b1);
      check("R5 word lanes", 64'(prio[31:0]), 64'h4433_2211);
      rd(A_PRIO + 12'd2, SZ_BYTE, 1'b1, d);
      check("R5 byte read", d, 64'h33);
      wr(A_PRIO + 12'd4, SZ_BYTE, 64'h40, 1'b0);
      check("R4 ns write view", 64'(prio[39:32]), 64'hA0);
      rd(A_PRIO + 12'd4, SZ_BYTE, 1'b0, d);
      check("R3 ns byte read view", d, 64'h40);
      rd(A_PRIO + 12'd4, SZ_WORD, 1'b0, d);
      check("R3 ns word read view", d, 64'h0000_0040);
      rd(A_PRIO + 12'd4, SZ_WORD, 1'b1, d);
      check("R3 secure raw read", d, 64'h0000_00A0);
      wr(A_PRIO + 12'd1, SZ_BYTE, 64'hFF, 1'b0);
      check("R4 ns write to group0 ignored", 64'(prio[31:0]), 64'h4433_2211);
      rd(A_PRIO, SZ_WORD, 1'b0, d);
      check("R3 ns read group0 zero", d, 64'h0);
      dis = 1'b1;
      wr(A_PRIO + 12'd5, SZ_BYTE, 64'h40, 1'b0);
      check("R4 disabled raw write", 64'(prio[47:40]), 64'h40);
      dis = 1'b0;
   endtask

   task automatic t_group();
      logic [63:0] d;
      rd(A_GROUP, SZ_WORD, 1'b0, d);
      check("R6 ns group read zero", d, 64'h0);
      wr(A_GROUP, SZ_WORD, 64'h0000_FFFF, 1'b0);
      check("R6 ns group write ignored", 64'(grp), 64'h0000_00F0);
      wr(A_GROUP, SZ_WORD, 64'h0000_FF00, 1'b1);
      check("R6 secure group write", 64'(grp), 64'h0000_FF00);
      wr(A_GROUP, SZ_WORD, 64'h0000_00F0, 1'b1);
      dis = 1'b1;
      rd(A_GROUP, SZ_WORD, 1'b0, d);
      check("R6 disabled ns read", d, 64'h0000_00F0);
      dis = 1'b0;
   endtask

   task automatic t_cfg();
      logic [63:0] d;
      wr(A_GMOD, SZ_WORD, 64'h5, 1'b1);
      check("R7 secure grpmod write", 64'(gmod), 64'h5);
      wr(A_GMOD, SZ_WORD, 64'hF, 1'b0);
      check("R7 ns grpmod ignored", 64'(gmod), 64'h5);
      rd(A_GMOD, SZ_WORD, 1'b0, d);
      check("R7 ns grpmod read zero", d, 64'h0);
      rd(A_GMOD, SZ_WORD, 1'b1, d);
      check("R7 secure grpmod read", d, 64'h5);
      dis = 1'b1;
      wr(A_GMOD, SZ_WORD, 64'h0, 1'b1);
      check("R7 disabled write ignored", 64'(gmod), 64'h5);
      rd(A_GMOD, SZ_WORD, 1'b1, d);
      check("R7 disabled read zero", d, 64'h0);
      dis = 1'b0;
      wr(A_SGIAC, SZ_WORD, 64'hAAAA_5555, 1'b1);
      check("R7 access word write", 64'(sgiac), 64'hAAAA_5555);
      wr(A_SGIAC, SZ_WORD, 64'h0, 1'b0);
      check("R7 ns access word ignored", 64'(sgiac), 64'hAAAA_5555);
   endtask

   task automatic t_sleep();
      logic [63:0] d;
      wr(A_SLEEP, SZ_WORD, 64'hFFFF_FFFF, 1'b1);
      rd(A_SLEEP, SZ_WORD, 1'b1, d);
      check("R8 sleep set", d, 64'h3);
      wr(A_SLEEP, SZ_WORD, 64'hFFFF_FFFE, 1'b1);
      rd(A_SLEEP, SZ_WORD, 1'b1, d);
      check("R8 sleep cleared by bit0", d, 64'h0);
   endtask

   task automatic t_ro();
      logic [63:0] d;
      wr(A_CTRL, SZ_WORD, 64'hFFFF_FFFF, 1'b1);
      rd(A_CTRL, SZ_WORD, 1'b1, d);
      check("R9 control RAZ", d, 64'h0);
      wr(A_STAT, SZ_WORD, 64'hFFFF_FFFF, 1'b1);
      rd(A_STAT, SZ_WORD, 1'b1, d);
      check("R9 status RAZ", d, 64'h0);
      rd(A_TYPE_LO, SZ_DWORD, 1'b1, d);
      check("R9 type dword", d, TVAL);
      rd(A_TYPE_HI, SZ_WORD, 1'b1, d);
      check("R9 type high half", d, 64'h0123_4567);
      wr(A_TYPE_LO, SZ_DWORD, 64'h0, 1'b1);
      rd(A_TYPE_LO, SZ_WORD, 1'b1, d);
      check("R9 type write ignored", d, 64'h89AB_CDEF);
   endtask

   task automatic t_base();
      logic [63:0] d;
      wr(A_BASEA_LO, SZ_DWORD, 64'h1111_2222_3333_4444, 1'b1);
      rd(A_BASEA_LO, SZ_WORD, 1'b1, d);
      check("R10 base low half", d, 64'h3333_4444);
      rd(A_BASEA_HI, SZ_WORD, 1'b1, d);
      check("R10 base high half", d, 64'h1111_2222);
      wr(A_BASEB_HI, SZ_WORD, 64'hDEAD_BEEF, 1'b0);
      rd(A_BASEB_LO, SZ_DWORD, 1'b0, d);
      check("R10 half write dword read", d, 64'hDEAD_BEEF_0000_0000);
   endtask

   task automatic t_bad();
      logic [63:0] d;
      rd(A_GROUP, SZ_HALF, 1'b1, d);
      check("R11 half read zero", d, 64'h0);
      wr(A_EN_SET, SZ_HALF, 64'hFFFF_FFFF, 1'b1);
      check("R11 half write ignored", 64'(en), 64'hFFFF_FF00);
      rd(12'h7F0, SZ_WORD, 1'b1, d);
      check("R11 unmapped read zero", d, 64'h0);
      rd(A_GROUP, SZ_BYTE, 1'b1, d);
      check("R11 byte on word reg zero", d, 64'h0);
      rd(A_GROUP, SZ_DWORD, 1'b1, d);
      check("R11 dword on word reg zero", d, 64'h0);
      wr(A_BASEA_LO, SZ_BYTE, 64'hFF, 1'b1);
      rd(A_BASEA_LO, SZ_DWORD, 1'b1, d);
      check("R11 byte write to base ignored", d, 64'h1111_2222_3333_4444);
      wr(A_PRIO + 12'd2, SZ_WORD, 64'hFFFF_FFFF, 1'b1);
      check("R11 misaligned prio write ignored", 64'(prio[31:0]), 64'h4433_2211);
   endtask

   task automatic t_hold();
      logic [63:0] d;
      rd(A_BASEA_HI, SZ_WORD, 1'b1, d);
      repeat (3) @(negedge clk);
      check("R12 rdata holds when idle", rdata, 64'h1111_2222);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask();
      t_pend_act();
      t_prio();
      t_group();
      t_cfg();
      t_sleep();
      t_ro();
      t_base();
      t_bad();
      t_hold();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule